// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked lock controller that releases only after a fixed sequence of values has been presented in the right order. A value is offered on a small input bus and marked by a one-cycle entry strobe. The controller walks through one state per digit. After the last correct digit it reaches an unlocked state. Any wrong digit sends it to a locked-out state that only reset leaves. The stored sequence is 3, then 4, then 2.

Internally the block is split into a data path and a controller. The data path holds the stored digits, steers one of them with a one-hot selector, and feeds a single shared equality comparator. The controller is a state machine whose digit-state bits double as that selector. A state code with all bits clear means locked out. Any code outside the legal set is treated the same way. The state code and the selector are brought to ports so that the encoding can be observed.

Top module: `combo_lock`

## Requirements
- R1: A synchronous, active-high `rst` puts the state at 4'b0001 (first digit) with `digit_sel_o` = 3'b001 and `unlocked_o` = 0 on the following cycle, from any state.
- R2: In a digit state (0001, 0010 or 0100), a cycle with `entry_stb` low leaves `state_o` and `digit_sel_o` unchanged, whatever `entry_val` carries.
- R3: In state 0001 or 0010, `entry_stb` high with a matching `entry_val` moves to the next digit state (0010 or 0100), and `digit_sel_o` moves from 001 to 010, or from 010 to 100.
- R4: In state 0100, `entry_stb` high with a matching value moves to the unlocked state 1000, where `digit_sel_o` reads 000.
- R5: In any digit state, `entry_stb` high with a value that does not match goes to the locked-out state 0000, where `digit_sel_o` reads 000.
- R6: States 1000 and 0000 keep their code for every strobe and value until reset.
- R7: `unlocked_o` is 1 exactly in the cycles when `state_o` is 1000, and is 0 otherwise.
- R8: The stored sequence is 3, 4, 2 in entry order. In the first digit state, each of the other fifteen 4-bit values leads to lock-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| entry_stb | input | 1 | One-cycle mark that `entry_val` holds a new digit |
| entry_val | input | VAL_W (4) | Digit being offered |
| unlocked_o | output | 1 | 1 = unlocked, 0 = locked (registered) |
| state_o | output | NUM_DIGITS+1 (4) | Controller state code |
| digit_sel_o | output | NUM_DIGITS (3) | One-hot pick of the stored digit under comparison |

## Verification
The bench builds the block with its default parameters: four-bit values, three digits and the sequence 3, 4, 2. With these values the full input space of the first digit can be swept, every digit position can be given a wrong value, and every state code can be compared against the fixed four-bit encoding. Idle stretches between entries show that nothing advances without a strobe. Strobes applied in the unlocked and locked-out states show that both are absorbing, and a reset issued in the middle of a sequence shows that reset recovers the block from any state.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned LOCK_VAL_W_DEF  = 4;
  localparam int unsigned LOCK_DIGITS_DEF = 3;

  typedef enum logic [1:0] {
    PH_DIGIT = 2'd0,
    PH_OPEN  = 2'd1,
    PH_LOCK  = 2'd2,
    PH_BAD   = 2'd3
  } lock_phase_e;
endpackage

// File: rtl/lock_key_path.sv
module lock_key_path
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W      = LOCK_VAL_W_DEF,
  parameter int unsigned NUM_DIGITS = LOCK_DIGITS_DEF,
  parameter logic [NUM_DIGITS-1:0][VAL_W-1:0] KEY = '{4'd2, 4'd4, 4'd3}
) (
  input  logic [NUM_DIGITS-1:0] sel_i,
  input  logic [VAL_W-1:0]      val_i,
  output logic                  hit_o
);
  logic [NUM_DIGITS-1:0] lane_hit;
  logic [VAL_W-1:0]      picked;

  // one-hot steering of the stored digit onto a single comparator
  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (sel_i[i]) picked = picked | KEY[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_lane
      assign lane_hit[g] = sel_i[g];
    end
  endgenerate

  assign hit_o = (|lane_hit) && (picked == val_i);
endmodule

// File: rtl/lock_seq_ctrl.sv
module lock_seq_ctrl
  import lock_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = LOCK_DIGITS_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe_i,
  input  logic                hit_i,
  output logic [NUM_DIGITS:0] state_o,
  output logic                open_o
);
  localparam int unsigned ST_W = NUM_DIGITS + 1;
  localparam logic [ST_W-1:0] ST_FIRST = ST_W'(1);
  localparam logic [ST_W-1:0] ST_OPEN  = ST_W'(1) << NUM_DIGITS;
  localparam logic [ST_W-1:0] ST_LOCK  = '0;

  logic [ST_W-1:0] state_q, state_d;
  logic            open_q;
  lock_phase_e     phase;

  always_comb begin
    if (state_q == ST_LOCK)
      phase = PH_LOCK;
    else if (state_q == ST_OPEN)
      phase = PH_OPEN;
    else if (!state_q[NUM_DIGITS] && $onehot(state_q[NUM_DIGITS-1:0]))
      phase = PH_DIGIT;
    else
      phase = PH_BAD;
  end

  always_comb begin
    unique case (phase)
      PH_DIGIT: begin
        if (strobe_i) state_d = hit_i ? (state_q << 1) : ST_LOCK;
        else          state_d = state_q;
      end
      PH_OPEN:  state_d = ST_OPEN;
      PH_LOCK:  state_d = ST_LOCK;
      default:  state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FIRST;
      open_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      open_q  <= (state_d == ST_OPEN);
    end
  end

  assign state_o = state_q;
  assign open_o  = open_q;
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W      = LOCK_VAL_W_DEF,
  parameter int unsigned NUM_DIGITS = LOCK_DIGITS_DEF,
  parameter logic [NUM_DIGITS-1:0][VAL_W-1:0] KEY = '{4'd2, 4'd4, 4'd3}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  entry_stb,
  input  logic [VAL_W-1:0]      entry_val,
  output logic                  unlocked_o,
  output logic [NUM_DIGITS:0]   state_o,
  output logic [NUM_DIGITS-1:0] digit_sel_o
);
  logic [NUM_DIGITS:0] state_w;
  logic                key_hit;

  lock_key_path #(
    .VAL_W(VAL_W), .NUM_DIGITS(NUM_DIGITS), .KEY(KEY)
  ) u_path (
    .sel_i (state_w[NUM_DIGITS-1:0]),
    .val_i (entry_val),
    .hit_o (key_hit)
  );

  lock_seq_ctrl #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (entry_stb),
    .hit_i    (key_hit),
    .state_o  (state_w),
    .open_o   (unlocked_o)
  );

  assign state_o     = state_w;
  assign digit_sel_o = state_w[NUM_DIGITS-1:0];
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
  parameter int unsigned NUM_DIGITS = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  entry_stb,
  input logic                  key_hit,
  input logic                  unlocked_o,
  input logic [NUM_DIGITS:0]   state_o,
  input logic [NUM_DIGITS-1:0] digit_sel_o
);
  localparam logic [NUM_DIGITS:0] S_FIRST = (NUM_DIGITS+1)'(1);
  localparam logic [NUM_DIGITS:0] S_LAST  = (NUM_DIGITS+1)'(1) << (NUM_DIGITS-1);
  localparam logic [NUM_DIGITS:0] S_OPEN  = (NUM_DIGITS+1)'(1) << NUM_DIGITS;

  logic in_digit;
  assign in_digit = !state_o[NUM_DIGITS] && (state_o != '0);

  AST_RESET_FIRST: assert property (@(posedge clk)
    rst |=> (state_o == S_FIRST) && !unlocked_o); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_digit && !entry_stb) |=> $stable(state_o) && $stable(digit_sel_o)); // R2

  AST_STEP_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (in_digit && entry_stb && key_hit) |=> (state_o == $past(state_o) << 1)); // R3

  AST_OPEN_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> $past(entry_stb) && ($past(state_o) == S_LAST)); // R4

  AST_MISS_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (in_digit && entry_stb && !key_hit) |=> (state_o == '0)); // R5

  AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_o == S_OPEN) |=> (state_o == S_OPEN)); // R6

  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_o == '0) |=> (state_o == '0)); // R6

  AST_OUT_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
    ##1 (unlocked_o == (state_o == S_OPEN))); // R7

  AST_STATE_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    ##1 $onehot0(state_o)); // R1

  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    ##1 $onehot0(digit_sel_o)); // R3
endmodule

bind combo_lock combo_lock_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .entry_stb   (entry_stb),
  .key_hit     (key_hit),
  .unlocked_o  (unlocked_o),
  .state_o     (state_o),
  .digit_sel_o (digit_sel_o)
);

// File: tb/tb_combo_lock.sv
module tb_combo_lock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       entry_stb = 1'b0;
  logic [3:0] entry_val = '0;
  logic       unlocked_o;
  logic [3:0] state_o;
  logic [2:0] digit_sel_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 0;

  always #4 clk = ~clk; // 125 MHz

  combo_lock dut (
    .clk(clk), .rst(rst), .entry_stb(entry_stb), .entry_val(entry_val),
    .unlocked_o(unlocked_o), .state_o(state_o), .digit_sel_o(digit_sel_o)
  );

  // row: req[3:0] rst stb val[3:0] exp_state[3:0] exp_sel[2:0] exp_open
  localparam int NV = 21;
  localparam logic [17:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 4'd0, 4'b0001, 3'b001, 1'b0}, // R1 reset
    {4'd2, 1'b0, 1'b0, 4'd3, 4'b0001, 3'b001, 1'b0}, // R2 idle, right value on bus
    {4'd8, 1'b0, 1'b1, 4'd3, 4'b0010, 3'b010, 1'b0}, // R8 first digit 3
    {4'd2, 1'b0, 1'b0, 4'd9, 4'b0010, 3'b010, 1'b0}, // R2 idle
    {4'd3, 1'b0, 1'b1, 4'd4, 4'b0100, 3'b100, 1'b0}, // R3 second digit 4
    {4'd4, 1'b0, 1'b1, 4'd2, 4'b1000, 3'b000, 1'b1}, // R4 third digit 2
    {4'd6, 1'b0, 1'b1, 4'd7, 4'b1000, 3'b000, 1'b1}, // R6 strobe while open
    {4'd7, 1'b0, 1'b0, 4'd0, 4'b1000, 3'b000, 1'b1}, // R7 stays open
    {4'd1, 1'b1, 1'b0, 4'd0, 4'b0001, 3'b001, 1'b0}, // R1 reset from open
    {4'd5, 1'b0, 1'b1, 4'd4, 4'b0000, 3'b000, 1'b0}, // R5 wrong first
    {4'd6, 1'b0, 1'b1, 4'd3, 4'b0000, 3'b000, 1'b0}, // R6 right value in lock-out
    {4'd1, 1'b1, 1'b0, 4'd0, 4'b0001, 3'b001, 1'b0}, // R1 reset from lock-out
    {4'd3, 1'b0, 1'b1, 4'd3, 4'b0010, 3'b010, 1'b0}, // R3
    {4'd5, 1'b0, 1'b1, 4'd3, 4'b0000, 3'b000, 1'b0}, // R5 wrong second
    {4'd1, 1'b1, 1'b0, 4'd0, 4'b0001, 3'b001, 1'b0}, // R1
    {4'd3, 1'b0, 1'b1, 4'd3, 4'b0010, 3'b010, 1'b0}, // R3
    {4'd3, 1'b0, 1'b1, 4'd4, 4'b0100, 3'b100, 1'b0}, // R3
    {4'd5, 1'b0, 1'b1, 4'd4, 4'b0000, 3'b000, 1'b0}, // R5 wrong third
    {4'd1, 1'b1, 1'b0, 4'd0, 4'b0001, 3'b001, 1'b0}, // R1
    {4'd3, 1'b0, 1'b1, 4'd3, 4'b0010, 3'b010, 1'b0}, // R3
    {4'd1, 1'b1, 1'b1, 4'd4, 4'b0001, 3'b001, 1'b0}  // R1 reset beats strobe
  };

  task automatic check(input int req, input logic [3:0] es, input logic [2:0] esel,
                       input logic eo, input string tag);
    total++;
    if (state_o !== es || digit_sel_o !== esel || unlocked_o !== eo) begin
      bad++;
      $display("FAIL R%0d %s: state=%b sel=%b open=%b expected state=%b sel=%b open=%b",
               req, tag, state_o, digit_sel_o, unlocked_o, es, esel, eo);
    end
  endtask

  // drive on falling edge, result visible at the next falling edge
  task automatic step(input logic r, input logic s, input logic [3:0] v);
    rst = r; entry_stb = s; entry_val = v;
    @(negedge clk);
    rst = 1'b0; entry_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:8]);
      check(int'(VEC[i][17:14]), VEC[i][7:4], VEC[i][3:1], VEC[i][0], $sformatf("vector %0d", i));
    end

    // R2: long idle gaps between correct entries with noise on the bus
    step(1'b1, 1'b0, 4'd0);
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 5; j++) step(1'b0, 1'b0, 4'(j * 3 + k));
      case (k)
        0: check(2, 4'b0001, 3'b001, 1'b0, "idle before first");
        1: check(2, 4'b0010, 3'b010, 1'b0, "idle before second");
        default: check(2, 4'b0100, 3'b100, 1'b0, "idle before third");
      endcase
      step(1'b0, 1'b1, (k == 0) ? 4'd3 : (k == 1) ? 4'd4 : 4'd2);
    end
    check(4, 4'b1000, 3'b000, 1'b1, "open after gapped entry");

    // R6/R7: every value strobed while open
    for (int v = 0; v < 16; v++) step(1'b0, 1'b1, 4'(v));
    check(6, 4'b1000, 3'b000, 1'b1, "open after all values");

    // R8: every wrong first value locks out, and lock-out ignores all values
    for (int v = 0; v < 16; v++) begin
      if (v == 3) continue;
      step(1'b1, 1'b0, 4'd0);
      step(1'b0, 1'b1, 4'(v));
      check(8, 4'b0000, 3'b000, 1'b0, $sformatf("first value %0d", v));
    end
    for (int v = 0; v < 16; v++) step(1'b0, 1'b1, 4'(v));
    check(6, 4'b0000, 3'b000, 1'b0, "lock-out after all values");

    // R7: the output is low in each state passed on the way to open
    step(1'b1, 1'b0, 4'd0);
    check(7, 4'b0001, 3'b001, 1'b0, "closed in first");
    step(1'b0, 1'b1, 4'd3);
    check(7, 4'b0010, 3'b010, 1'b0, "closed in second");
    step(1'b0, 1'b1, 4'd4);
    check(7, 4'b0100, 3'b100, 1'b0, "closed in third");
    step(1'b0, 1'b1, 4'd2);
    check(7, 4'b1000, 3'b000, 1'b1, "open at end");

    finish_run();
  end
endmodule